// File: doc/BRIEF.md
# USB Host Port-Reset Speed Tracker

This block follows the port-reset handshake on the host side of a USB 2.0 controller. It reports the negotiated connection speed as a 3-bit status code and pulses a change flag whenever that code moves. Software starts a handshake by writing 1 to a bus-reset control bit and ends it by writing 0. The transceiver reports what it sees on the wire as single-cycle strobes: a Chirp-K from the peripheral, low-speed or full-speed attach, and the end of SE0 driving.

During the handshake the status code shows an in-progress value. It reads 100 after the reset starts and 111 once a high-speed chirp is seen with high-speed operation enabled. The final speed is fixed only after two things: software has released the reset bit, and the transceiver has finished driving SE0. A host test mode forces the code to read high speed for as long as it is selected. The handshake state underneath still moves, and it shows again once test mode ends.

Every status change appears on the clock edge that samples the event that causes it. The status and the change pulse are both registered.

Top module: `usbh_rst_track`

## Requirements
- R1: A synchronous active-high `rst` sets `spd_code` to 000 and `spd_chg` to 0 on the next clock edge, and that state holds until some later event changes it.
- R2: The codes are 000 for undetermined, 001 for low speed, 010 for full speed and 011 for high speed. Any code with bit 2 set (1xx) means a handshake is in progress.
- R3: A cycle with `rst_wr`=1 and `rst_wdata`=1 makes `spd_code` read 100 after that edge, from any state. It also discards any earlier chirp and attach observations. `rst_wr`=1 with `rst_wdata`=0 clears the reset bit.
- R4: While a handshake is in progress and the reset bit reads 1, a `chirp_k` strobe with `hs_en`=1 makes the code read 111 after that edge. With `hs_en`=0 the strobe is ignored and the code stays 100.
- R5: After the reset bit is cleared, the code keeps its 1xx value until `se0_done` is seen in a cycle where the reset bit already reads 0. A `se0_done` in the same cycle as the clearing write, or while the bit reads 1, is ignored.
- R6: At resolution a code of 111 becomes 011. Otherwise the last attach indication decides: `ls_attach` gives 001, and `fs_attach` or no indication gives 010. If both arrive in one cycle, low speed wins. Attach strobes count only while the reset bit reads 1.
- R7: While `test_mode[3]`=1 the code reads 011. The handshake keeps tracking events underneath, and its value shows once `test_mode[3]` returns to 0.
- R8: `spd_chg` is 1 for exactly the cycles in which `spd_code` differs from its value one cycle earlier.
- R9: A clearing write or a `se0_done` strobe with no handshake in progress leaves the code unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| rst_wr | input | 1 | Write strobe for the bus-reset control bit |
| rst_wdata | input | 1 | Value written to the bus-reset control bit |
| hs_en | input | 1 | High-speed operation enabled |
| test_mode | input | 4 | Host test-mode field; bit 3 set forces high speed |
| chirp_k | input | 1 | Chirp-K from the peripheral detected |
| ls_attach | input | 1 | Low-speed attach seen |
| fs_attach | input | 1 | Full-speed attach seen |
| se0_done | input | 1 | Transceiver finished SE0 driving |
| spd_code | output | 3 | Connection speed / handshake status code |
| spd_chg | output | 1 | One-cycle pulse on a status code change |

## Verification
The bench sends a `se0_done` strobe while the reset bit is still set, and another in the same cycle as the clearing write. A design that latched early would show a final speed before the reset was released. It also sends a chirp with high speed disabled and attach strobes after release. A design that did not ignore them would report 111/011 or low speed by mistake. Test mode is raised in the middle of a handshake and then dropped, to catch an override that freezes or corrupts the state underneath. The change pulse is compared on every clock, so a pulse that is late, missing or stuck would be reported.

// File: rtl/usbh_rst_pkg.sv
package usbh_rst_pkg;
  localparam int CODE_W = 3;
  typedef logic [CODE_W-1:0] spd_code_t;

  localparam spd_code_t SPD_NONE  = 3'b000;
  localparam spd_code_t SPD_LOW   = 3'b001;
  localparam spd_code_t SPD_FULL  = 3'b010;
  localparam spd_code_t SPD_HIGH  = 3'b011;
  localparam spd_code_t SPD_BUSY  = 3'b100;
  localparam spd_code_t SPD_CHIRP = 3'b111;
endpackage

// File: rtl/usbh_rst_ctl.sv
module usbh_rst_ctl (
  input  logic clk,
  input  logic rst,
  input  logic wr,
  input  logic wdata,
  output logic set_req,
  output logic bit_q
);
  assign set_req = wr & wdata;

  always_ff @(posedge clk) begin
    if (rst)     bit_q <= 1'b0;
    else if (wr) bit_q <= wdata;
  end
endmodule

// File: rtl/usbh_rst_engine.sv
module usbh_rst_engine
  import usbh_rst_pkg::*;
(
  input  logic      clk,
  input  logic      rst,
  input  logic      set_req,
  input  logic      bit_q,
  input  logic      hs_en,
  input  logic      chirp_k,
  input  logic      ls_attach,
  input  logic      fs_attach,
  input  logic      se0_done,
  output spd_code_t hs_d,
  output spd_code_t hs_q
);
  logic lo_q, lo_d;
  logic busy;

  assign busy = hs_q[CODE_W-1];

  always_comb begin
    hs_d = hs_q;
    lo_d = lo_q;
    if (set_req) begin
      hs_d = SPD_BUSY;
      lo_d = 1'b0;
    end else if (busy) begin
      if (bit_q) begin
        if (hs_en && chirp_k) hs_d = SPD_CHIRP;
        if (ls_attach)        lo_d = 1'b1;
        else if (fs_attach)   lo_d = 1'b0;
      end else if (se0_done) begin
        if (hs_q == SPD_CHIRP) hs_d = SPD_HIGH;
        else if (lo_q)         hs_d = SPD_LOW;
        else                   hs_d = SPD_FULL;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hs_q <= SPD_NONE;
      lo_q <= 1'b0;
    end else begin
      hs_q <= hs_d;
      lo_q <= lo_d;
    end
  end

  // R4
  chirp_to_busy_hs_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && bit_q && hs_en && chirp_k && !set_req) |=> (hs_q == SPD_CHIRP));

  // R5
  hold_until_se0_chk: assert property (@(posedge clk) disable iff (rst)
    (busy && !bit_q && !se0_done && !set_req) |=> (hs_q == $past(hs_q)));

  // R6
  chirp_resolves_high_chk: assert property (@(posedge clk) disable iff (rst)
    (hs_q == SPD_CHIRP && !bit_q && se0_done && !set_req) |=> (hs_q == SPD_HIGH));
endmodule

// File: rtl/usbh_rst_status.sv
module usbh_rst_status
  import usbh_rst_pkg::*;
#(
  parameter int TMODE_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [TMODE_W-1:0] test_mode,
  input  spd_code_t          hs_d,
  output spd_code_t          code_q,
  output logic               chg_q
);
  localparam int OVR_BIT = TMODE_W - 1;

  spd_code_t code_d;

  assign code_d = test_mode[OVR_BIT] ? SPD_HIGH : hs_d;

  always_ff @(posedge clk) begin
    if (rst) begin
      code_q <= SPD_NONE;
      chg_q  <= 1'b0;
    end else begin
      code_q <= code_d;
      chg_q  <= (code_d != code_q);
    end
  end

  // R8
  chg_means_diff_chk: assert property (@(posedge clk) disable iff (rst)
    chg_q |-> (code_q != $past(code_q)));
endmodule

// File: rtl/usbh_rst_track.sv
module usbh_rst_track
  import usbh_rst_pkg::*;
#(
  parameter int TMODE_W = 4
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               rst_wr,
  input  logic               rst_wdata,
  input  logic               hs_en,
  input  logic [TMODE_W-1:0] test_mode,
  input  logic               chirp_k,
  input  logic               ls_attach,
  input  logic               fs_attach,
  input  logic               se0_done,
  output logic [2:0]         spd_code,
  output logic               spd_chg
);
  localparam int OVR_BIT = TMODE_W - 1;

  logic      set_req, bit_q;
  spd_code_t hs_d, hs_q, code_q;

  usbh_rst_ctl u_ctl (
    .clk(clk), .rst(rst), .wr(rst_wr), .wdata(rst_wdata),
    .set_req(set_req), .bit_q(bit_q)
  );

  usbh_rst_engine u_eng (
    .clk(clk), .rst(rst), .set_req(set_req), .bit_q(bit_q),
    .hs_en(hs_en), .chirp_k(chirp_k), .ls_attach(ls_attach),
    .fs_attach(fs_attach), .se0_done(se0_done),
    .hs_d(hs_d), .hs_q(hs_q)
  );

  usbh_rst_status #(.TMODE_W(TMODE_W)) u_stat (
    .clk(clk), .rst(rst), .test_mode(test_mode), .hs_d(hs_d),
    .code_q(code_q), .chg_q(spd_chg)
  );

  assign spd_code = code_q;

  // R3
  start_shows_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (rst_wr && rst_wdata && !test_mode[OVR_BIT]) |=> (spd_code == SPD_BUSY));

  // R7
  test_override_chk: assert property (@(posedge clk) disable iff (rst)
    test_mode[OVR_BIT] |=> (spd_code == SPD_HIGH));

  // R8
  diff_means_chg_chk: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && spd_code != $past(spd_code)) |-> spd_chg);
endmodule

// File: tb/usbh_rst_track_test.sv
module usbh_rst_track_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       rst_wr = 0, rst_wdata = 0, hs_en = 0;
  logic [3:0] test_mode = 4'd0;
  logic       chirp_k = 0, ls_attach = 0, fs_attach = 0, se0_done = 0;
  logic [2:0] spd_code;
  logic       spd_chg;

  int n_cmp = 0, n_bad = 0;

  // reference model state
  int m_bit, m_act, m_k, m_lo, m_fin, m_code, m_chg;

  always #4 clk = ~clk;

  usbh_rst_track uut (
    .clk(clk), .rst(rst), .rst_wr(rst_wr), .rst_wdata(rst_wdata),
    .hs_en(hs_en), .test_mode(test_mode), .chirp_k(chirp_k),
    .ls_attach(ls_attach), .fs_attach(fs_attach), .se0_done(se0_done),
    .spd_code(spd_code), .spd_chg(spd_chg)
  );

  always @(posedge clk) begin
    int shown;
    if (rst) begin
      m_bit = 0; m_act = 0; m_k = 0; m_lo = 0; m_fin = 0; m_code = 0; m_chg = 0;
    end else begin
      if (rst_wr && rst_wdata) begin
        m_act = 1; m_k = 0; m_lo = 0;
      end else if (m_act == 1) begin
        if (m_bit == 1) begin
          if (hs_en && chirp_k) m_k = 1;
          if (ls_attach) m_lo = 1;
          else if (fs_attach) m_lo = 0;
        end else if (se0_done) begin
          m_fin = (m_k == 1) ? 3 : ((m_lo == 1) ? 1 : 2);
          m_act = 0;
        end
      end
      if (rst_wr) m_bit = rst_wdata ? 1 : 0;
      shown = (m_act == 1) ? ((m_k == 1) ? 7 : 4) : m_fin;
      if (test_mode[3]) shown = 3;
      m_chg = (shown != m_code) ? 1 : 0;
      m_code = shown;
    end
  end

  // lockstep comparison every cycle (R2 code values, R8 pulse)
  always @(negedge clk) begin
    if (!rst) begin
      n_cmp++;
      if (spd_code !== m_code[2:0] || spd_chg !== m_chg[0]) begin
        n_bad++;
        $display("FAIL R2/R8 lockstep t=%0t: code=%b chg=%b expected code=%b chg=%b",
                 $time, spd_code, spd_chg, m_code[2:0], m_chg[0]);
      end
    end
  end

  task automatic chk(input string tag, input logic [2:0] ec, input logic echg);
    n_cmp++;
    if (spd_code !== ec || spd_chg !== echg) begin
      n_bad++;
      $display("FAIL %s: code=%b chg=%b expected code=%b chg=%b",
               tag, spd_code, spd_chg, ec, echg);
    end
  endtask

  task automatic quiet();
    rst_wr = 0; rst_wdata = 0; chirp_k = 0; ls_attach = 0;
    fs_attach = 0; se0_done = 0;
  endtask

  // drive for one edge, then sit at the following negedge
  task automatic tick();
    @(negedge clk);
    quiet();
  endtask

  task automatic start_hs(); rst_wr = 1; rst_wdata = 1; tick(); endtask
  task automatic release_hs(); rst_wr = 1; rst_wdata = 0; tick(); endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    chk("R1 reset state", 3'b000, 1'b0);

    start_hs();
    chk("R3 start shows 100", 3'b100, 1'b1);
    tick();
    chk("R8 pulse one cycle", 3'b100, 1'b0);

    hs_en = 0; chirp_k = 1; tick();
    chk("R4 chirp ignored hs_en=0", 3'b100, 1'b0);
    hs_en = 1; chirp_k = 1; tick();
    chk("R4 chirp gives 111", 3'b111, 1'b1);

    se0_done = 1; tick();
    chk("R5 se0 while bit set ignored", 3'b111, 1'b0);
    rst_wr = 1; rst_wdata = 0; se0_done = 1; tick();
    chk("R5 se0 with clearing write ignored", 3'b111, 1'b0);
    tick();
    chk("R5 holds after release", 3'b111, 1'b0);
    se0_done = 1; tick();
    chk("R6 111 resolves 011", 3'b011, 1'b1);

    hs_en = 0;
    start_hs();
    chk("R3 restart from final", 3'b100, 1'b1);
    ls_attach = 1; tick();
    release_hs();
    se0_done = 1; tick();
    chk("R6 low speed 001", 3'b001, 1'b1);

    rst_wr = 1; rst_wdata = 1; ls_attach = 1; tick();
    fs_attach = 1; tick();
    release_hs();
    ls_attach = 1; tick();
    se0_done = 1; tick();
    chk("R6 full speed, late low ignored", 3'b010, 1'b1);

    start_hs();
    ls_attach = 1; fs_attach = 1; tick();
    release_hs();
    se0_done = 1; tick();
    chk("R6 low wins same cycle", 3'b001, 1'b1);

    test_mode = 4'b1000; tick();
    chk("R7 override 011", 3'b011, 1'b1);
    hs_en = 1;
    start_hs();
    chk("R7 override during start", 3'b011, 1'b0);
    chirp_k = 1; tick();
    test_mode = 4'b0111; tick();
    chk("R7 underlying 111 revealed", 3'b111, 1'b1);
    release_hs();
    se0_done = 1; tick();
    chk("R6 after test mode", 3'b011, 1'b1);

    release_hs();
    chk("R9 clearing write idle", 3'b011, 1'b0);
    se0_done = 1; tick();
    chk("R9 se0 idle", 3'b011, 1'b0);

    start_hs();
    rst = 1; tick(); rst = 0;
    chk("R1 reset mid handshake", 3'b000, 1'b0);

    for (int i = 0; i < 3000; i++) begin
      @(negedge clk);
      rst_wr    = ($urandom % 8) == 0;
      rst_wdata = $urandom % 2;
      hs_en     = ($urandom % 4) != 0;
      test_mode = (($urandom % 16) == 0) ? 4'b1000 : 4'($urandom % 8);
      chirp_k   = ($urandom % 6) == 0;
      ls_attach = ($urandom % 7) == 0;
      fs_attach = ($urandom % 7) == 0;
      se0_done  = ($urandom % 5) == 0;
      rst       = ($urandom % 500) == 0;
    end
    @(negedge clk);
    quiet(); rst = 0;
    repeat (2) @(negedge clk);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: run did not end, expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule